// File: doc/BRIEF.md
# Programmable-Sense External Interrupt Controller

This block watches a set of external interrupt pins and turns activity on them into one interrupt output per line for a parent interrupt controller. Each pin is first brought into the bus clock domain by a two-stage synchronizer. A per-line sense code then selects what counts as an event: a low level, a high level, a falling edge, a rising edge or either edge. Events are latched in a detect bit, and the detect bit is gated by a per-line enable to form the line's interrupt output.

Software reaches the block through a simple 32-bit register port with a write strobe, an address, write data and combinationally returned read data. The enable mask has separate set and clear addresses, so individual lines can be changed without a read-modify-write. Detect bits are cleared by writing ones. Every line has its own configuration word, and the current synchronized pin levels can be read back.

Top module: `sense_irq_ctrl`

## Requirements
- R1: After reset all enables and detect bits are 0, every configuration word reads 0, and all interrupt outputs are low.
- R2: The configuration word of line n sits at byte offset 0x180 + 4*n, stores all 32 written bits and reads them back unchanged; bits [5:0] hold the sense code.
- R3: Sense code 0x02 (high level) sets the detect bit on every clock while the synchronized level is 1, so a clear written while the pin is still high leaves the bit set; once the level is 0 a clear takes effect.
- R4: Sense code 0x01 (low level) behaves as R3 with the active level 0.
- R5: Sense codes 0x08 (rising), 0x04 (falling) and 0x0C (both) set the detect bit when the synchronized sample differs from the previous one in the selected direction; a pin change is visible on the detect bit after the third rising clock edge.
- R6: Any other sense code, including 0x00 and 0x03, never sets the detect bit.
- R7: Offset 0x100 reads the detect bits (bit n for line n); writing 1 clears a bit and writing 0 leaves it unchanged.
- R8: Writing 1s to offset 0x08 sets those enable bits, writing 1s to offset 0x04 clears them, and reading either offset returns the enable mask; enables change only on such writes.
- R9: Offset 0x00 reads detect AND enable, and interrupt output n is high exactly when detect bit n and enable bit n are both 1.
- R10: Offset 0x104 returns the synchronized pin levels, each reflecting a pin change after the second rising clock edge.
- R11: When a line's event and a clearing write to its detect bit fall on the same clock edge, the detect bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, all logic rising-edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | NUM_LINES | External interrupt pins, asynchronous |
| irq_out | output | NUM_LINES | Per-line interrupt to the parent controller |

## Verification
The two functions that can meet on one clock edge are a newly detected event and a software clear of the same detect bit. The bench raises a rising-edge pin and times a write-one-to-clear so that it is sampled on exactly the edge where the event latches, then reads the detect register and expects the bit to remain set; it also clears a level-sensed line while the pin is still active and expects the bit to reappear. A behavioural model built on a history queue of pin samples predicts outputs and read data every cycle, and directed checks pin down latency, gating and the clear rules.

// File: rtl/sic_pkg.sv
package sic_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned CODE_W = 6;

    localparam logic [BUS_W-1:0] OFS_PEND     = 32'h0000_0000;
    localparam logic [BUS_W-1:0] OFS_EN_CLR   = 32'h0000_0004;
    localparam logic [BUS_W-1:0] OFS_EN_SET   = 32'h0000_0008;
    localparam logic [BUS_W-1:0] OFS_DET      = 32'h0000_0100;
    localparam logic [BUS_W-1:0] OFS_MON      = 32'h0000_0104;
    localparam logic [BUS_W-1:0] OFS_CFG_BASE = 32'h0000_0180;

    localparam logic [CODE_W-1:0] CODE_LOW  = 6'h01;
    localparam logic [CODE_W-1:0] CODE_HIGH = 6'h02;
    localparam logic [CODE_W-1:0] CODE_FALL = 6'h04;
    localparam logic [CODE_W-1:0] CODE_RISE = 6'h08;
    localparam logic [CODE_W-1:0] CODE_BOTH = 6'h0C;

    typedef enum logic [2:0] {
        SENSE_OFF,
        SENSE_LOW,
        SENSE_HIGH,
        SENSE_FALL,
        SENSE_RISE,
        SENSE_BOTH
    } sense_e;

    typedef struct packed {
        logic level;
        logic prev;
    } sample_t;

    function automatic sense_e decode_sense(input logic [CODE_W-1:0] code);
        case (code)
            CODE_LOW:  return SENSE_LOW;
            CODE_HIGH: return SENSE_HIGH;
            CODE_FALL: return SENSE_FALL;
            CODE_RISE: return SENSE_RISE;
            CODE_BOTH: return SENSE_BOTH;
            default:   return SENSE_OFF;
        endcase
    endfunction

    function automatic logic sense_hit(input sense_e mode, input sample_t s);
        case (mode)
            SENSE_LOW:  return !s.level;
            SENSE_HIGH: return s.level;
            SENSE_FALL: return s.prev && !s.level;
            SENSE_RISE: return !s.prev && s.level;
            SENSE_BOTH: return s.prev != s.level;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] cfg_offset(input int unsigned idx);
        return OFS_CFG_BASE + BUS_W'(4 * idx);
    endfunction

endpackage

// File: rtl/sic_sync.sv
module sic_sync #(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] pin,
    output logic [NUM_LINES-1:0] level,
    output logic [NUM_LINES-1:0] prev
);
    logic [NUM_LINES-1:0] meta_q;
    logic [NUM_LINES-1:0] level_q;
    logic [NUM_LINES-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q  <= '0;
            level_q <= '0;
            prev_q  <= '0;
        end else begin
            meta_q  <= pin;
            level_q <= meta_q;
            prev_q  <= level_q;
        end
    end

    assign level = level_q;
    assign prev  = prev_q;
endmodule

// File: rtl/sic_line.sv
module sic_line
    import sic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    input  sample_t           smp,
    input  logic              clr,
    output logic              det
);
    sense_e mode;
    logic   hit;
    logic   det_q;

    always_comb begin
        mode = decode_sense(code);
        hit  = sense_hit(mode, smp);
    end

    // A fresh event outranks a software clear on the same edge.
    always_ff @(posedge clk) begin
        if (rst) det_q <= 1'b0;
        else     det_q <= hit | (det_q & ~clr);
    end

    assign det = det_q;
endmodule

// File: rtl/sic_regs.sv
module sic_regs
    import sic_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             bus_wr,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [BUS_W-1:0]                 bus_wdata,
    output logic [BUS_W-1:0]                 bus_rdata,
    input  logic [NUM_LINES-1:0]             det,
    input  logic [NUM_LINES-1:0]             level,
    output logic [NUM_LINES-1:0]             en,
    output logic [NUM_LINES-1:0]             det_clr,
    output logic [NUM_LINES-1:0][CODE_W-1:0] code
);
    logic [BUS_W-1:0]     addr_w;
    logic [NUM_LINES-1:0] wmask;
    logic [NUM_LINES-1:0] en_q;
    logic [BUS_W-1:0]     cfg_q [NUM_LINES];

    assign addr_w = BUS_W'(bus_addr);
    assign wmask  = bus_wdata[NUM_LINES-1:0];

    always_ff @(posedge clk) begin
        if (rst)                                 en_q <= '0;
        else if (bus_wr && addr_w == OFS_EN_SET) en_q <= en_q | wmask;
        else if (bus_wr && addr_w == OFS_EN_CLR) en_q <= en_q & ~wmask;
    end

    assign det_clr = (bus_wr && addr_w == OFS_DET) ? wmask : '0;
    assign en      = en_q;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_cfg
        localparam logic [BUS_W-1:0] MY_OFS = cfg_offset(g);
        always_ff @(posedge clk) begin
            if (rst)                             cfg_q[g] <= '0;
            else if (bus_wr && addr_w == MY_OFS) cfg_q[g] <= bus_wdata;
        end
        assign code[g] = cfg_q[g][CODE_W-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        if (addr_w == OFS_PEND)
            bus_rdata[NUM_LINES-1:0] = det & en_q;
        else if (addr_w == OFS_EN_CLR || addr_w == OFS_EN_SET)
            bus_rdata[NUM_LINES-1:0] = en_q;
        else if (addr_w == OFS_DET)
            bus_rdata[NUM_LINES-1:0] = det;
        else if (addr_w == OFS_MON)
            bus_rdata[NUM_LINES-1:0] = level;
        else begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (addr_w == cfg_offset(i)) bus_rdata = cfg_q[i];
            end
        end
    end
endmodule

// File: rtl/sense_irq_ctrl.sv
module sense_irq_ctrl
    import sic_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] irq_out
);
    logic [NUM_LINES-1:0]             lvl_vec;
    logic [NUM_LINES-1:0]             prv_vec;
    logic [NUM_LINES-1:0]             det_vec;
    logic [NUM_LINES-1:0]             en_vec;
    logic [NUM_LINES-1:0]             clr_vec;
    logic [NUM_LINES-1:0][CODE_W-1:0] code_vec;

    sic_sync #(.NUM_LINES(NUM_LINES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin   (irq_in),
        .level (lvl_vec),
        .prev  (prv_vec)
    );

    sic_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .det       (det_vec),
        .level     (lvl_vec),
        .en        (en_vec),
        .det_clr   (clr_vec),
        .code      (code_vec)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        sample_t smp;
        assign smp.level = lvl_vec[g];
        assign smp.prev  = prv_vec[g];
        sic_line u_line (
            .clk  (clk),
            .rst  (rst),
            .code (code_vec[g]),
            .smp  (smp),
            .clr  (clr_vec[g]),
            .det  (det_vec[g])
        );
    end

    assign irq_out = det_vec & en_vec;
endmodule

// File: rtl/sic_checker.sv
module sic_checker
    import sic_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned ADDR_W    = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_LINES-1:0] irq_out,
    input logic [NUM_LINES-1:0] en_q
);
    logic [31:0]          a32;
    logic [NUM_LINES-1:0] wm;
    assign a32 = 32'(bus_addr);
    assign wm  = bus_wdata[NUM_LINES-1:0];

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (irq_out == '0)); // R1

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        ((irq_out & ~en_q) == '0)); // R9

    AST_PENDING_READ: assert property (@(posedge clk) disable iff (rst)
        (a32 == OFS_PEND) |-> (bus_rdata[NUM_LINES-1:0] == irq_out)); // R9

    AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && a32 == OFS_EN_SET) |=> ((en_q & $past(wm)) == $past(wm))); // R8

    AST_EN_CLR: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && a32 == OFS_EN_CLR) |=> ((en_q & $past(wm)) == '0)); // R8

    AST_EN_QUIET: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(en_q)); // R8
endmodule

bind sense_irq_ctrl sic_checker #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .en_q      (en_vec)
);

// File: tb/sense_irq_ctrl_test.sv
module sense_irq_ctrl_test;
    localparam int N  = 32;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr  = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [N-1:0]  pins = '0;
    logic [N-1:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sense_irq_ctrl #(.NUM_LINES(N), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_in(pins), .irq_out(irq)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_det = '0;
    logic [31:0] m_en  = '0;
    logic [31:0] m_cfg [N];
    logic [31:0] hist [$];

    initial begin
        for (int i = 0; i < N; i++) m_cfg[i] = '0;
        hist = '{32'h0, 32'h0, 32'h0, 32'h0};
    end

    always @(posedge clk) begin
        if (rst) begin
            m_det = '0;
            m_en  = '0;
            for (int i = 0; i < N; i++) m_cfg[i] = '0;
            hist = '{32'h0, 32'h0, 32'h0, 32'h0};
        end else begin
            logic [31:0] evt;
            logic [31:0] clr;
            logic [31:0] a;
            logic lv, pv;
            evt = '0;
            for (int i = 0; i < N; i++) begin
                lv = hist[1][i];
                pv = hist[2][i];
                case (m_cfg[i][5:0])
                    6'h01: evt[i] = !lv;
                    6'h02: evt[i] = lv;
                    6'h04: evt[i] = pv && !lv;
                    6'h08: evt[i] = !pv && lv;
                    6'h0C: evt[i] = pv != lv;
                    default: evt[i] = 1'b0;
                endcase
            end
            a   = 32'(addr);
            clr = (wr && a == 32'h100) ? wdata : 32'h0;
            m_det = evt | (m_det & ~clr);
            if (wr && a == 32'h008) m_en = m_en | wdata;
            if (wr && a == 32'h004) m_en = m_en & ~wdata;
            for (int i = 0; i < N; i++)
                if (wr && a == 32'h180 + 32'(4 * i)) m_cfg[i] = wdata;
            hist.push_front(32'(pins));
            if (hist.size() > 4) void'(hist.pop_back());
        end
    end

    function automatic logic [31:0] mread(input logic [31:0] a);
        if (a == 32'h000) return m_det & m_en;
        if (a == 32'h004 || a == 32'h008) return m_en;
        if (a == 32'h100) return m_det;
        if (a == 32'h104) return hist[1];
        for (int i = 0; i < N; i++)
            if (a == 32'h180 + 32'(4 * i)) return m_cfg[i];
        return 32'h0;
    endfunction

    function automatic string req_of(input logic [31:0] a);
        if (a == 32'h000) return "R9";
        if (a == 32'h004 || a == 32'h008) return "R8";
        if (a == 32'h100) return "R7";
        if (a == 32'h104) return "R10";
        return "R2";
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(32'(irq), m_det & m_en, "R9", "irq_out vs model");
            chk(rdata, mread(32'(addr)), req_of(32'(addr)), "read vs model");
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        wr = 1'b1; addr = AW'(a); wdata = d;
        step(1);
        wr = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] v);
        step(1);
        addr = AW'(a);
        #1 v = rdata;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        pins = 32'h0000_000A;
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        #1;
        chk(32'(irq), 32'h0, "R1", "irq_out after reset");
        rd(32'h004, v); chk(v, 32'h0, "R1", "enable mask after reset");
        rd(32'h100, v); chk(v, 32'h0, "R1", "detect after reset");
        rd(32'h180, v); chk(v, 32'h0, "R1", "config 0 after reset");
        rd(32'h1FC, v); chk(v, 32'h0, "R1", "config 31 after reset");

        // sense codes: 0 high, 1 low, 2 rise, 3 fall, 4 both, 5 invalid
        bus_write(32'h180, 32'hABCD_0002);
        bus_write(32'h184, 32'h0000_0001);
        bus_write(32'h188, 32'h0000_0008);
        bus_write(32'h18C, 32'h0000_0004);
        bus_write(32'h190, 32'h0000_000C);
        bus_write(32'h194, 32'h0000_0003);
        rd(32'h180, v); chk(v, 32'hABCD_0002, "R2", "config 0 readback");
        rd(32'h194, v); chk(v, 32'h0000_0003, "R2", "config 5 readback");
        rd(32'h100, v); chk(v, 32'h0, "R6", "no event with idle pins");

        bus_write(32'h008, 32'h0000_003F);
        rd(32'h004, v); chk(v, 32'h3F, "R8", "enable set");
        bus_write(32'h004, 32'h0000_0020);
        rd(32'h008, v); chk(v, 32'h1F, "R8", "enable clear");

        // rising edge latency on line 2
        pins[2] = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        chk(32'(irq[2]), 32'h0, "R5", "rise not yet after two edges");
        @(posedge clk); #1;
        chk(32'(irq[2]), 32'h1, "R5", "rise after third edge");

        pins = pins | 32'h31;
        step(4);
        rd(32'h100, v);
        chk(32'(v[0]), 32'h1, "R3", "high level detected");
        chk(32'(v[4]), 32'h1, "R5", "both-edge rise detected");
        chk(32'(v[5]), 32'h0, "R6", "invalid code 0x03 ignored");
        chk(v, 32'h15, "R7", "detect image");
        rd(32'h000, v); chk(v, 32'h15, "R9", "pending image");

        bus_write(32'h100, 32'h0);
        rd(32'h100, v); chk(v, 32'h15, "R7", "writing zero keeps bits");
        bus_write(32'h100, 32'h15);
        rd(32'h100, v);
        chk(32'(v[0]), 32'h1, "R3", "clear while high re-sets");
        chk(v, 32'h01, "R7", "edge bits cleared");

        pins = pins & ~32'h19;
        step(4);
        rd(32'h100, v);
        chk(32'(v[3]), 32'h1, "R5", "falling edge detected");
        chk(32'(v[4]), 32'h1, "R5", "both-edge fall detected");
        bus_write(32'h100, 32'h01);
        rd(32'h100, v); chk(32'(v[0]), 32'h0, "R3", "clear after level gone");

        pins[1] = 1'b0;
        step(4);
        rd(32'h100, v); chk(32'(v[1]), 32'h1, "R4", "low level detected");
        bus_write(32'h100, 32'h02);
        rd(32'h100, v); chk(32'(v[1]), 32'h1, "R4", "clear while low re-sets");
        pins[1] = 1'b1;
        step(4);
        bus_write(32'h100, 32'h02);
        rd(32'h100, v); chk(32'(v[1]), 32'h0, "R4", "clear after level gone");

        // event and clear on the same edge
        pins[2] = 1'b0;
        step(4);
        bus_write(32'h100, 32'h04);
        rd(32'h100, v); chk(32'(v[2]), 32'h0, "R11", "line 2 cleared first");
        pins[2] = 1'b1;
        @(posedge clk); @(posedge clk); #2;
        wr = 1'b1; addr = AW'(32'h100); wdata = 32'h04;
        @(posedge clk); #2;
        wr = 1'b0;
        rd(32'h100, v); chk(32'(v[2]), 32'h1, "R11", "event beats clear");

        // monitor latency
        addr = AW'(32'h104);
        pins[6] = 1'b1;
        @(posedge clk); #1;
        chk(32'(rdata[6]), 32'h0, "R10", "monitor after one edge");
        @(posedge clk); #1;
        chk(32'(rdata[6]), 32'h1, "R10", "monitor after two edges");
        rd(32'h104, v); chk(v, 32'(pins), "R10", "monitor image");
        rd(32'h100, v); chk(32'(v[6]), 32'h0, "R6", "code 0 ignores pin");

        // enable gating
        bus_write(32'h004, 32'h10);
        #1 chk(32'(irq[4]), 32'h0, "R9", "disabled line masked");
        rd(32'h100, v); chk(32'(v[4]), 32'h1, "R9", "detect kept while masked");
        bus_write(32'h008, 32'h10);
        #1 chk(32'(irq[4]), 32'h1, "R9", "re-enabled line fires");

        bus_write(32'h180, 32'hABCD_0008);
        rd(32'h180, v); chk(v, 32'hABCD_0008, "R2", "config rewrite");
        step(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule